// File: doc/BRIEF.md
# Microcontroller Interrupt Control Unit

This block gates and sequences interrupts for a small 8-bit processor core. Four request sources are each captured into a sticky flag bit. The sources are:

- a synchronized external pin, which raises its flag on a rising edge;
- a timer overflow pulse;
- a change on four upper port pins;
- a comparator event pulse.

Flags latch whatever the masks say. The flags are combined with per-source enables, a peripheral-group enable (which gates only the comparator) and a global enable. The result is a single request line to the CPU. A separate wake output goes high when an enabled flag is set while the core sleeps. The wake output ignores the global enable.

Requests are evaluated once per instruction cycle, on a `tick` strobe from the core, into a registered pending bit. When the CPU acknowledges a pending request, the unit does three things in one step:

- it clears the global enable;
- it emits a push strobe carrying the return address;
- it emits a vector load to the fixed vector address.

A return-from-interrupt strobe sets the global enable again. When software clears the global enable with a register write, any pending request is withdrawn and the next evaluation tick is skipped. The flags stay set, so the request is taken later.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the global enable, group enable, all enables and all flags read 0, and irq_req, wake, push_en and vec_load are 0.
- R2: Register select 0 is the control register: bit 7 global enable, bit 6 group enable, bits 5/4/3 enables for port-change/timer/pin, bits 2/1/0 flags for port-change/timer/pin. Select 1 holds the comparator flag in bit 0, and select 2 holds the comparator enable in bit 0. Select 3 and all unused bits read 0. rd_data shows the register chosen by rd_sel one clock later.
- R3: Each flag sets on its event regardless of its enable, the group enable or the global enable. A flag clears only when software writes 0 to it. An event in the same cycle as a clearing write leaves the flag set.
- R4: The pin flag sets on a rising edge of ext_pin after a two-flop synchronizer. The port-change flag sets whenever the synchronized port_hi differs from a snapshot, and that snapshot is loaded on each port_rd pulse.
- R5: irq_req rises only in the clock after a tick. It does so when the global enable is set and either an enabled core flag is set, or the group enable, the comparator enable and the comparator flag are all set.
- R6: irq_ack while irq_req is high gives, one clock later: irq_req 0, global enable 0, push_en high with push_addr equal to ret_pc, and vec_load high with vec_pc equal to VEC_ADDR (default 4). push_en and vec_load are one-clock pulses.
- R7: A retfie pulse sets the global enable. With a flag still enabled and set, the request is raised again at the next tick.
- R8: A control write that clears a set global enable drops irq_req on the next clock and suppresses the next tick's evaluation even if the enable is set again before it. The flags stay set, and the request is raised at a later tick once the global enable is set.
- R9: wake is the registered value of sleeping AND (any enabled source active, with the group rule of R5), independent of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle evaluation strobe |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_hi | input | PW | Asynchronous upper port pins |
| cmp_evt | input | 1 | Comparator event pulse |
| port_rd | input | 1 | Software port read strobe, loads the change snapshot |
| sleeping | input | 1 | Core is in sleep mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | 8 | Registered read data |
| irq_ack | input | 1 | CPU takes the pending interrupt |
| retfie | input | 1 | Return-from-interrupt strobe |
| ret_pc | input | AW | Return address to save |
| irq_req | output | 1 | Registered interrupt request |
| wake | output | 1 | Registered wake-up request |
| push_en | output | 1 | Stack push strobe |
| push_addr | output | AW | Address to push |
| vec_load | output | 1 | Program counter vector load strobe |
| vec_pc | output | AW | Vector address |

## Verification
The hardest situation to reach is the suppressed tick of R8. It needs a request already pending, then a write that clears the global enable, then a write that sets it again, all before the next tick. The bench drives `tick` by hand, so it can place exactly these two writes between ticks. It then checks that one tick yields no request and the following tick does. Random rounds draw enable masks and event sets with a fixed seed. In each round the flag register, wake and request are compared against expected values from bench functions, with the global enable held off while the flags are read back.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W      = 8;
  localparam int NCORE      = 3;   // index 0 pin, 1 timer, 2 port change
  localparam int CTRL_GIE   = 7;
  localparam int CTRL_GRP   = 6;
  localparam int CTRL_EN_LO = 3;
  localparam int CTRL_F_LO  = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PFLG = 2'd1,
    SEL_PEN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_s,
  input  logic [PW-1:0] port_s,
  input  logic          port_rd,
  output logic          pin_rise,
  output logic          port_chg
);
  logic          pin_prev;
  logic [PW-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev <= 1'b0;
      snap     <= '0;
    end else begin
      pin_prev <= pin_s;
      if (port_rd) snap <= port_s;
    end
  end

  assign pin_rise = pin_s & ~pin_prev;
  assign port_chg = |(port_s ^ snap);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  input  logic [NCORE-1:0] ev_core,
  input  logic             ev_cmp,
  input  logic             take,
  input  logic             retfie,
  output logic             gie,
  output logic             grp_en,
  output logic [NCORE-1:0] core_en,
  output logic [NCORE-1:0] core_f,
  output logic             cmp_f,
  output logic             cmp_en,
  output logic             gie_drop,
  output logic [REG_W-1:0] rd_data
);
  logic wr_ctrl, wr_pflg, wr_pen;

  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
  assign wr_pflg  = wr_en && (wr_sel == SEL_PFLG);
  assign wr_pen   = wr_en && (wr_sel == SEL_PEN);
  assign gie_drop = wr_ctrl && !wr_data[CTRL_GIE] && gie;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie     <= 1'b0;
      grp_en  <= 1'b0;
      core_en <= '0;
      core_f  <= '0;
      cmp_f   <= 1'b0;
      cmp_en  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (take)         gie <= 1'b0;
      else if (retfie)  gie <= 1'b1;
      else if (wr_ctrl) gie <= wr_data[CTRL_GIE];

      if (wr_ctrl) begin
        grp_en  <= wr_data[CTRL_GRP];
        core_en <= wr_data[CTRL_EN_LO +: NCORE];
        core_f  <= wr_data[CTRL_F_LO +: NCORE] | ev_core;
      end else begin
        core_f  <= core_f | ev_core;
      end

      if (wr_pflg) cmp_f <= wr_data[0] | ev_cmp;
      else         cmp_f <= cmp_f | ev_cmp;

      if (wr_pen) cmp_en <= wr_data[0];

      case (rd_sel)
        SEL_CTRL: rd_data <= {gie, grp_en, core_en, core_f};
        SEL_PFLG: rd_data <= {{(REG_W-1){1'b0}}, cmp_f};
        SEL_PEN:  rd_data <= {{(REG_W-1){1'b0}}, cmp_en};
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int          AW       = 11,
  parameter logic [AW-1:0] VEC_ADDR = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gie,
  input  logic          active,
  input  logic          gie_drop,
  input  logic          irq_ack,
  input  logic          sleeping,
  input  logic [AW-1:0] ret_pc,
  output logic          irq_req,
  output logic          take,
  output logic          wake,
  output logic          push_en,
  output logic [AW-1:0] push_addr,
  output logic          vec_load,
  output logic [AW-1:0] vec_pc
);
  logic hold;

  assign take = irq_ack & irq_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      hold      <= 1'b0;
      wake      <= 1'b0;
      push_en   <= 1'b0;
      push_addr <= '0;
      vec_load  <= 1'b0;
      vec_pc    <= '0;
    end else begin
      push_en  <= take;
      vec_load <= take;
      if (take) begin
        push_addr <= ret_pc;
        vec_pc    <= VEC_ADDR;
      end
      wake <= sleeping & active;
      if (take || gie_drop) begin
        irq_req <= 1'b0;
        hold    <= gie_drop;
      end else if (tick) begin
        irq_req <= gie & active & ~hold;
        hold    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_pkg::*;
#(
  parameter int            PW       = 4,
  parameter int            AW       = 11,
  parameter logic [AW-1:0] VEC_ADDR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ext_pin,
  input  logic             tmr_ovf,
  input  logic [PW-1:0]    port_hi,
  input  logic             cmp_evt,
  input  logic             port_rd,
  input  logic             sleeping,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             irq_ack,
  input  logic             retfie,
  input  logic [AW-1:0]    ret_pc,
  output logic             irq_req,
  output logic             wake,
  output logic             push_en,
  output logic [AW-1:0]    push_addr,
  output logic             vec_load,
  output logic [AW-1:0]    vec_pc
);
  localparam int SW = PW + 1;

  logic [SW-1:0]    sync_q;
  logic             pin_rise, port_chg;
  logic             gie, grp_en, cmp_f, cmp_en, gie_drop, take, active;
  logic [NCORE-1:0] core_en, core_f, ev_core;

  irq_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(rst), .d({port_hi, ext_pin}), .q(sync_q)
  );

  irq_capture #(.PW(PW)) u_cap (
    .clk(clk), .rst(rst), .pin_s(sync_q[0]), .port_s(sync_q[SW-1:1]),
    .port_rd(port_rd), .pin_rise(pin_rise), .port_chg(port_chg)
  );

  assign ev_core = {port_chg, tmr_ovf, pin_rise};

  irq_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .ev_core(ev_core), .ev_cmp(cmp_evt), .take(take),
    .retfie(retfie), .gie(gie), .grp_en(grp_en), .core_en(core_en),
    .core_f(core_f), .cmp_f(cmp_f), .cmp_en(cmp_en), .gie_drop(gie_drop),
    .rd_data(rd_data)
  );

  assign active = (|(core_f & core_en)) | (grp_en & cmp_en & cmp_f);

  irq_seq #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .gie(gie), .active(active),
    .gie_drop(gie_drop), .irq_ack(irq_ack), .sleeping(sleeping),
    .ret_pc(ret_pc), .irq_req(irq_req), .take(take), .wake(wake),
    .push_en(push_en), .push_addr(push_addr), .vec_load(vec_load),
    .vec_pc(vec_pc)
  );
endmodule

// File: rtl/irq_ctrl_unit_chk.sv
module irq_ctrl_unit_chk #(
  parameter int            AW       = 11,
  parameter logic [AW-1:0] VEC_ADDR = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          sleeping,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [7:0]    wr_data,
  input logic          irq_ack,
  input logic [AW-1:0] ret_pc,
  input logic          irq_req,
  input logic          wake,
  input logic          push_en,
  input logic [AW-1:0] push_addr,
  input logic          vec_load,
  input logic [AW-1:0] vec_pc
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_req && !wake && !push_en && !vec_load));

  assert_req_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(tick));

  assert_take_vector_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> (vec_load && push_en && vec_pc == VEC_ADDR && !irq_req));

  assert_take_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> (push_addr == $past(ret_pc)));

  assert_pulse_one_R6: assert property (@(posedge clk) disable iff (rst)
    push_en |=> !push_en);

  assert_drop_on_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && !wr_data[7]) |=> !irq_req);

  assert_wake_needs_sleep_R9: assert property (@(posedge clk) disable iff (rst)
    !sleeping |=> !wake);
endmodule

bind irq_ctrl_unit irq_ctrl_unit_chk #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sleeping(sleeping), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack), .ret_pc(ret_pc),
  .irq_req(irq_req), .wake(wake), .push_en(push_en), .push_addr(push_addr),
  .vec_load(vec_load), .vec_pc(vec_pc)
);

// File: tb/sim_irq_ctrl_unit.sv
`timescale 1ns/1ps
module sim_irq_ctrl_unit;
  localparam int PW = 4;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 0, ext_pin = 0, tmr_ovf = 0, cmp_evt = 0, port_rd = 0;
  logic          sleeping = 0, wr_en = 0, irq_ack = 0, retfie = 0;
  logic [PW-1:0] port_hi = '0;
  logic [1:0]    wr_sel = 0, rd_sel = 0;
  logic [7:0]    wr_data = 0;
  logic [7:0]    rd_data;
  logic [AW-1:0] ret_pc = '0;
  logic          irq_req, wake, push_en, vec_load;
  logic [AW-1:0] push_addr, vec_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ctrl_unit #(.PW(PW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_hi(port_hi), .cmp_evt(cmp_evt), .port_rd(port_rd), .sleeping(sleeping),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_ack(irq_ack), .retfie(retfie), .ret_pc(ret_pc),
    .irq_req(irq_req), .wake(wake), .push_en(push_en), .push_addr(push_addr),
    .vec_load(vec_load), .vec_pc(vec_pc)
  );

  function automatic bit exp_active(input bit grp, input bit [2:0] en,
                                    input bit [2:0] fl, input bit cf, input bit ce);
    return (|(en & fl)) | (grp & cf & ce);
  endfunction

  function automatic bit [7:0] ctrl_word(input bit g, input bit grp,
                                         input bit [2:0] en, input bit [2:0] fl);
    return {g, grp, en, fl};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit [1:0] sel, input bit [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input bit [1:0] sel, output bit [7:0] v);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit [7:0] v;
    int unsigned seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    cyc(3);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_req", irq_req, 0);
    check("R1 wake", wake, 0);
    check("R1 push_en", push_en, 0);
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 pflg", v, 0);
    rd(2'd2, v); check("R1 pen", v, 0);

    // R2 unused select reads 0, upper bits of peripheral regs read 0
    wr(2'd2, 8'hff);
    rd(2'd2, v); check("R2 pen bit0 only", v, 8'h01);
    rd(2'd3, v); check("R2 sel3 zero", v, 0);
    wr(2'd2, 8'h00);

    // R3 event beats clearing write in the same cycle
    tmr_ovf = 1; wr(2'd0, 8'h00); tmr_ovf = 0;
    rd(2'd0, v); check("R3 set beats clear", v, 8'h02);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R3 cleared by write", v, 8'h00);

    // R4 port-change flag re-sets until snapshot updated
    port_hi = 4'h9; cyc(4);
    rd(2'd0, v); check("R4 port change flag", v, 8'h04);
    wr(2'd0, 8'h00); cyc(1);
    rd(2'd0, v); check("R4 re-set while differing", v, 8'h04);
    port_rd = 1; cyc(1); port_rd = 0;
    wr(2'd0, 8'h00); cyc(2);
    rd(2'd0, v); check("R4 stays clear after port read", v, 8'h00);

    // R5 group gating of comparator
    cmp_evt = 1; cyc(1); cmp_evt = 0;
    wr(2'd2, 8'h01);
    wr(2'd0, ctrl_word(1, 0, 3'b000, 3'b000));
    do_tick(); check("R5 no req without group enable", irq_req, 0);
    wr(2'd0, ctrl_word(1, 1, 3'b000, 3'b000));
    cyc(2); check("R5 req waits for tick", irq_req, 0);
    do_tick(); check("R5 req with group enable", irq_req, 1);

    // R6 acknowledge
    ret_pc = 11'h123; irq_ack = 1; @(negedge clk); irq_ack = 0;
    check("R6 push_en", push_en, 1);
    check("R6 push_addr", push_addr, 11'h123);
    check("R6 vec_load", vec_load, 1);
    check("R6 vec_pc", vec_pc, 4);
    check("R6 req cleared", irq_req, 0);
    @(negedge clk);
    check("R6 push pulse ends", push_en, 0);
    rd(2'd0, v); check("R6 gie cleared", v[7], 0);
    do_tick(); check("R6 no req while gie off", irq_req, 0);

    // R7 retfie
    retfie = 1; @(negedge clk); retfie = 0;
    rd(2'd0, v); check("R7 gie set", v[7], 1);
    do_tick(); check("R7 req again", irq_req, 1);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R8 suppressed tick after clearing gie
    tmr_ovf = 1; wr(2'd0, ctrl_word(1, 0, 3'b010, 3'b000)); tmr_ovf = 0;
    do_tick(); check("R8 setup req", irq_req, 1);
    wr(2'd0, ctrl_word(0, 0, 3'b010, 3'b010));
    check("R8 req dropped", irq_req, 0);
    wr(2'd0, ctrl_word(1, 0, 3'b010, 3'b010));
    do_tick(); check("R8 tick suppressed", irq_req, 0);
    do_tick(); check("R8 pending serviced", irq_req, 1);
    wr(2'd0, 8'h00);

    // R9 wake independent of gie
    tmr_ovf = 1; wr(2'd0, ctrl_word(0, 0, 3'b010, 3'b000)); tmr_ovf = 0;
    sleeping = 1; cyc(2); check("R9 wake asleep", wake, 1);
    sleeping = 0; cyc(2); check("R9 wake awake", wake, 0);
    wr(2'd0, 8'h00);

    // Random rounds
    for (int it = 0; it < 60; it++) begin
      bit grp, ce, e_pin, e_tmr, e_chg, e_cmp, act;
      bit [2:0] en, fl;
      grp = 1'($urandom); ce = 1'($urandom); en = 3'($urandom);
      e_pin = 1'($urandom); e_tmr = 1'($urandom);
      e_chg = 1'($urandom); e_cmp = 1'($urandom);
      port_rd = 1; cyc(1); port_rd = 0;
      wr(2'd0, ctrl_word(0, grp, en, 3'b000));
      wr(2'd1, 8'h00); wr(2'd2, {7'b0, ce});
      ext_pin = e_pin;
      tmr_ovf = e_tmr; cmp_evt = e_cmp;
      if (e_chg) port_hi = port_hi ^ (4'($urandom) | 4'h1);
      @(negedge clk); tmr_ovf = 0; cmp_evt = 0;
      cyc(4);
      fl = {e_chg, e_tmr, e_pin};
      act = exp_active(grp, en, fl, e_cmp, ce);
      rd(2'd0, v); check("R3 random ctrl", v, ctrl_word(0, grp, en, fl));
      rd(2'd1, v); check("R3 random pflg", v, {7'b0, e_cmp});
      sleeping = 1; cyc(2); check("R9 random wake", wake, act);
      sleeping = 0;
      do_tick(); check("R5 random gie off", irq_req, 0);
      wr(2'd0, ctrl_word(1, grp, en, fl));
      do_tick(); check("R5 random req", irq_req, act);
      wr(2'd0, 8'h00);
      do_tick();
      ext_pin = 0;
      port_rd = 1; cyc(1); port_rd = 0;
      cyc(3);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule